// File: doc/BRIEF.md
# Zero-Suppressing Hit Packetizer

The block receives one crossing at a time: a bus holding every channel's common-mode-corrected ADC sample, together with the crossing's bunch number, sensor number and chip number. It keeps only the channels whose sample is strictly greater than a programmable threshold. It then turns the crossing into a short stream of words. The stream starts with an identification word, may carry a payload-size word, and then carries one word per kept hit.

A two-bit policy input decides when the identification and size words appear. A one-bit width input selects a 3-bit or 4-bit size field, and that choice limits how many hits a single crossing may send. Channels are scanned from the lowest number upward. When a crossing has more hits than the limit, the highest-numbered hits are dropped and the crossing is flagged.

Accepted crossings wait whole in an input queue. A stalled consumer therefore delays output but never cuts a crossing short.

Top module: `zs_hit_packer`

## Requirements
- R1: A channel is kept only when its sample is strictly greater than `cfg_threshold`. A sample equal to the threshold produces no hit word.
- R2: A hit word carries the channel number in bits [12:6] and the sample in bits [5:0], with the upper bits zero. Hit words of one crossing appear in strictly ascending channel order.
- R3: The identification word is {bunch[11:0], sensor[7:0], chip[7:0]}, with the bunch number in bits [27:16]. It is the first word of every crossing that emits any word.
- R4: With `cfg_mode` = 1 (and also 0), the identification word is sent for every crossing. The size word, holding kept-count minus one, follows only when at least one hit exists.
- R5: With `cfg_mode` = 2, the identification word and the size word are sent for every crossing. The size word holds the kept count, so 0 means no hits.
- R6: With `cfg_mode` = 3, a crossing without hits emits no word at all. Otherwise it emits the identification word and a size word holding kept-count minus one.
- R7: The hit limit is 7 (narrow size field) or 15 (wide size field) in mode 2, and 8 or 16 in the other modes. `cfg_wide_size` = 1 selects the wide field. Only the lowest-numbered hits up to the limit are sent.
- R8: While a crossing is on the output, `out_overflow` is high exactly when its hit count exceeds the limit, and `out_dropped` equals the number of hits not sent.
- R9: While `out_ready` is low, the presented word holds steady. Up to DEPTH whole crossings are buffered, with `in_ready` low while the buffer is full, and no buffered crossing is lost or shortened.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: `out_kind` is 0 for identification, 1 for size and 2 for hit. `out_last` is high on exactly the final word of each crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Header policy (1, 2, 3; 0 acts as 1), latched per crossing |
| cfg_wide_size | input | 1 | 1 selects the 4-bit size field, 0 the 3-bit field |
| cfg_threshold | input | 6 | Keep threshold, latched per crossing |
| in_valid | input | 1 | Crossing offered |
| in_ready | output | 1 | Queue has room for a crossing |
| in_samples | input | 768 | Channel c sample in bits [6c+5:6c] |
| in_bunch | input | 12 | Bunch number |
| in_sensor | input | 8 | Sensor number |
| in_chip | input | 8 | Chip number |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 28 | Word content |
| out_kind | output | 2 | Word type |
| out_last | output | 1 | Final word of the crossing |
| out_overflow | output | 1 | Crossing exceeded the hit limit |
| out_dropped | output | 8 | Hits discarded from the crossing |

## Verification
Two things can happen in the same cycle: a crossing's hit list reaches the size limit, which truncates it and raises the overflow flag, and the consumer stalls in the middle of that truncated list. The bench provokes this by feeding crossings with more hits than the limit while `out_ready` toggles pseudo-randomly. It also holds ready low until the queue fills, and checks that `in_ready` drops. Each accepted word is compared with the bench's own model, which covers the truncation point, the count of dropped hits and the position of the last marker. A separate check confirms that a stalled word does not move.

// File: rtl/zs_hit_packer.sv
module zs_hit_packer #(
  parameter int N_CH   = 128,
  parameter int ADC_W  = 6,
  parameter int BX_W   = 12,
  parameter int SENS_W = 8,
  parameter int CHIP_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     cfg_mode,
  input  logic                           cfg_wide_size,
  input  logic [ADC_W-1:0]               cfg_threshold,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [N_CH*ADC_W-1:0]          in_samples,
  input  logic [BX_W-1:0]                in_bunch,
  input  logic [SENS_W-1:0]              in_sensor,
  input  logic [CHIP_W-1:0]              in_chip,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [BX_W+SENS_W+CHIP_W-1:0]  out_data,
  output logic [1:0]                     out_kind,
  output logic                           out_last,
  output logic                           out_overflow,
  output logic [$clog2(N_CH):0]          out_dropped
);
  localparam int CH_W  = $clog2(N_CH);
  localparam int CNT_W = CH_W + 1;
  localparam int HDR_W = BX_W + SENS_W + CHIP_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int S_W   = N_CH * ADC_W;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_SIZE, S_HIT} st_t;

  logic [S_W-1:0]   fifo_s [DEPTH];
  logic [HDR_W-1:0] fifo_h [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W:0]   cnt;

  st_t              st;
  logic [1:0]       cm;
  logic             cs4;
  logic [ADC_W-1:0] cthr;
  logic [N_CH-1:0]  pend, hit_mask;
  logic [CNT_W-1:0] total, sent, tot_now, lim, kept, size_val;
  logic [CH_W-1:0]  idx;
  logic [S_W-1:0]   head_s;
  logic [HDR_W-1:0] head_h;
  logic [ADC_W-1:0] adc;
  logic [1:0]       ld_mode;
  logic             push, pop, load, skip, fire, word_last;

  assign head_s   = fifo_s[rp];
  assign head_h   = fifo_h[rp];
  assign in_ready = cnt != (PTR_W+1)'(DEPTH);
  assign push     = in_valid && in_ready;
  assign out_valid = st != S_IDLE;
  assign fire     = out_valid && out_ready;
  assign ld_mode  = (cfg_mode == 2'd0) ? 2'd1 : cfg_mode;
  assign load     = (st == S_IDLE) && (cnt != '0);
  assign skip     = (ld_mode == 2'd3) && (tot_now == '0);
  assign pop      = (fire && word_last) || (load && skip);

  for (genvar g = 0; g < N_CH; g++) begin : g_cmp
    assign hit_mask[g] = head_s[g*ADC_W +: ADC_W] > cfg_threshold;
  end

  always_comb begin
    tot_now = '0;
    for (int i = 0; i < N_CH; i++) tot_now = tot_now + {{CH_W{1'b0}}, hit_mask[i]};
  end

  always_comb begin
    idx = '0;
    for (int i = N_CH-1; i >= 0; i--) if (pend[i]) idx = CH_W'(i);
  end

  assign adc      = head_s[idx*ADC_W +: ADC_W];
  assign lim      = (cm == 2'd2) ? (cs4 ? CNT_W'(15) : CNT_W'(7)) : (cs4 ? CNT_W'(16) : CNT_W'(8));
  assign kept     = (total > lim) ? lim : total;
  assign size_val = ((cm == 2'd2) ? kept : kept - 1'b1) & (cs4 ? CNT_W'(15) : CNT_W'(7));

  always_comb begin
    case (st)
      S_HDR:   word_last = (cm != 2'd2) && (kept == '0);
      S_SIZE:  word_last = kept == '0;
      S_HIT:   word_last = sent == kept - 1'b1;
      default: word_last = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      S_SIZE:  out_data = HDR_W'(size_val);
      S_HIT:   out_data = HDR_W'({idx, adc});
      default: out_data = head_h;
    endcase
  end

  assign out_kind     = (st == S_SIZE) ? 2'd1 : (st == S_HIT) ? 2'd2 : 2'd0;
  assign out_last     = out_valid && word_last;
  assign out_overflow = out_valid && (total > lim);
  assign out_dropped  = out_valid ? total - kept : '0;

  always_ff @(posedge clk) begin
    if (push) begin
      fifo_s[wp] <= in_samples;
      fifo_h[wp] <= {in_bunch, in_sensor, in_chip};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= '0; total <= '0; sent <= '0;
      cm <= 2'd1; cs4 <= 1'b0; cthr <= '0;
    end else if (load && !skip) begin
      pend  <= hit_mask;
      total <= tot_now;
      sent  <= '0;
      cm    <= ld_mode;
      cs4   <= cfg_wide_size;
      cthr  <= cfg_threshold;
      st    <= S_HDR;
    end else if (fire) begin
      case (st)
        S_HDR:  st <= word_last ? S_IDLE : S_SIZE;
        S_SIZE: st <= word_last ? S_IDLE : S_HIT;
        S_HIT: begin
          pend[idx] <= 1'b0;
          sent      <= sent + 1'b1;
          if (word_last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_kind) && $stable(out_last));

  assert_queue_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PTR_W+1)'(DEPTH));

  assert_hit_above_thr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd2 |-> out_data[ADC_W-1:0] > cthr);

  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd2 && $past(out_valid && out_ready && out_kind == 2'd2 && !out_last)
    |-> out_data[CH_W+ADC_W-1:ADC_W] > $past(out_data[CH_W+ADC_W-1:ADC_W]));

  assert_drop_needs_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_overflow |-> out_dropped == '0);

  assert_size_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd1 |-> out_data < (cs4 ? HDR_W'(16) : HDR_W'(8)));
endmodule

// File: tb/zs_hit_packer_test.sv
module zs_hit_packer_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cfg_mode = 2'd1;
  logic         cfg_wide_size = 1'b0;
  logic [5:0]   cfg_threshold = 6'd3;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [767:0] in_samples = '0;
  logic [11:0]  in_bunch = '0;
  logic [7:0]   in_sensor = '0, in_chip = '0;
  logic         out_valid, out_ready = 1'b0;
  logic [27:0]  out_data;
  logic [1:0]   out_kind;
  logic         out_last, out_overflow;
  logic [7:0]   out_dropped;

  int checks = 0, fails = 0, words = 0;
  bit force_low = 1'b0, jitter = 1'b0;
  logic [39:0] expq [$];

  always #2 clk = ~clk;

  zs_hit_packer uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wide_size(cfg_wide_size),
    .cfg_threshold(cfg_threshold), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .in_bunch(in_bunch), .in_sensor(in_sensor), .in_chip(in_chip),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_kind(out_kind),
    .out_last(out_last), .out_overflow(out_overflow), .out_dropped(out_dropped));

  // {mode, wide, hits, first channel, stride, expected word count}
  localparam logic [39:0] VEC [14] = '{
    40'h1000000101, 40'h1005031107, 40'h100810250A, 40'h1009050B0A,
    40'h2000000102, 40'h2007401309, 40'h2008022109, 40'h2114070911,
    40'h3000000100, 40'h30017F0103, 40'h3110220512, 40'h3180000112,
    40'h1110000312, 40'h1111010312 };

  initial forever begin
    @(posedge clk); #1;
    out_ready = force_low ? 1'b0 : (jitter ? ($urandom % 4 != 0) : 1'b1);
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [39:0] act, e;
      act = {out_kind, out_data, out_last, out_overflow, out_dropped};
      checks++; words++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R6/R11 unexpected word actual=%h expected=none", act);
      end else begin
        e = expq.pop_front();
        if (act !== e) begin
          fails++;
          if (e[39:38] == 2'd2)      $display("FAIL R2/R7/R8 hit word actual=%h expected=%h", act, e);
          else if (e[39:38] == 2'd1) $display("FAIL R4/R5/R7 size word actual=%h expected=%h", act, e);
          else                       $display("FAIL R3/R11 id word actual=%h expected=%h", act, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=drained");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [767:0] build(int nh, int start, int stride);
    logic [767:0] s;
    for (int c = 0; c < 128; c++) s[c*6 +: 6] = 6'(c % 4);
    for (int k = 0; k < nh; k++) s[((start + k*stride) % 128)*6 +: 6] = 6'(4 + (k*7) % 60);
    return s;
  endfunction

  task automatic model(int mode, bit wide, logic [27:0] hdr, logic [767:0] s, logic [5:0] thr);
    int chs[$];
    int total, lim, kept, drop;
    bit ovf;
    for (int c = 0; c < 128; c++) if (s[c*6 +: 6] > thr) chs.push_back(c);
    total = chs.size();
    lim   = (mode == 2) ? (wide ? 15 : 7) : (wide ? 16 : 8);
    kept  = (total > lim) ? lim : total;
    drop  = total - kept;
    ovf   = total > lim;
    if (mode == 3 && total == 0) return;
    expq.push_back({2'd0, hdr, (mode == 1 && kept == 0), ovf, 8'(drop)});
    if (mode == 2 || kept > 0)
      expq.push_back({2'd1, 28'((mode == 2) ? kept : kept - 1), (kept == 0), ovf, 8'(drop)});
    for (int k = 0; k < kept; k++)
      expq.push_back({2'd2, 28'({7'(chs[k]), s[chs[k]*6 +: 6]}), (k == kept - 1), ovf, 8'(drop)});
  endtask

  task automatic send(int mode, bit wide, logic [27:0] hdr, logic [767:0] s);
    bit acc;
    model(mode, wide, hdr, s, cfg_threshold);
    in_samples = s; {in_bunch, in_sensor, in_chip} = hdr; in_valid = 1'b1;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk);
    end while (!acc);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (expq.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (12) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);

    // table walk: covers R1 R2 R3 R4 R5 R6 R7 R8 R11 with a jittering consumer
    jitter = 1'b1;
    for (int r = 0; r < 14; r++) begin
      logic [39:0] v;
      v = VEC[r];
      @(posedge clk); #1;
      cfg_mode = v[37:36]; cfg_wide_size = v[32];
      words = 0;
      send(int'(v[39:36]), v[32], {12'(r*37 + 5), 8'(r + 1), 8'(r*3 + 2)},
           build(int'(v[31:24]), int'(v[23:16]), int'(v[15:8])));
      drain();
      check(words == int'(v[7:0]), "R4/R5/R6/R7", $sformatf("word count row %0d", r), words, int'(v[7:0]));
    end
    jitter = 1'b0;

    // R1 boundary: sample equal to threshold dropped, one above kept
    begin
      logic [767:0] s;
      s = '0; s[5*6 +: 6] = 6'd10; s[6*6 +: 6] = 6'd11;
      @(posedge clk); #1;
      cfg_mode = 2'd2; cfg_wide_size = 1'b0; cfg_threshold = 6'd10;
      words = 0;
      send(2, 1'b0, 28'h0ABCDEF, s);
      drain();
      check(words == 3, "R1", "threshold boundary word count", words, 3);
      cfg_threshold = 6'd3;
    end

    // R9: stall holds word, queue fills, nothing lost
    begin
      logic [27:0] held;
      force_low = 1'b1;
      @(posedge clk); #1;
      cfg_mode = 2'd2; cfg_wide_size = 1'b0;
      for (int q = 0; q < 4; q++) send(2, 1'b0, 28'(q*4099 + 1), build(9 + q, q, 3));
      @(negedge clk);
      check(in_ready == 1'b0, "R9", "in_ready with full queue", in_ready, 0);
      check(out_valid == 1'b1, "R9", "word presented while stalled", out_valid, 1);
      held = out_data;
      repeat (6) @(negedge clk);
      check(out_data == held && out_valid, "R9", "stalled word steady", int'(out_data), int'(held));
      force_low = 1'b0;
      drain();
      check(expq.size() == 0, "R9", "words left after drain", expq.size(), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule